// File: doc/BRIEF.md
# Power-Good Strap Capture and Test-Mode Control

This block samples two board-level frequency-select straps exactly once, on the first cycle in which an active-low power-good strobe, after a two-stage synchroniser, reads low. From that moment the captured pair is frozen. Later activity on the straps or on the strobe changes nothing until reset, which stands for a power cycle. The captured pair is decoded, together with a high-frequency control bit, into a CPU clock frequency code for the divider network. A direction control hands the shared strap pins over to their reference-clock output role once capture has happened.

A register-driven request puts the block into a sticky test mode. In that mode strap B is ignored. Pin A is turned back into an input, and its live level selects between high impedance on all clocks (A = 1) and a divided reference on all clocks (A = 0). The selection is combinational, so it follows A with no clock. Only reset leaves test mode.

Top module: `strap_latch_top`

## Requirements
- R1: While and just after reset, valid_o = 0, freq_code_o = 0 (100 MHz), latched_a_o = latched_b_o = 0, test_mode_o = 0, tristate_o = 0 and strap_oe_o = 2'b00.
- R2: Capture uses a two-stage synchroniser. If pwrgd_ni is low at rising edge 1, valid_o rises after edge 3, and latched_a_o/latched_b_o hold the strap levels present at that edge. After edge 2, valid_o is still 0.
- R3: Once valid_o is 1, changes on strap_a_i, strap_b_i or pwrgd_ni alter neither valid_o, the latched bits nor freq_code_o.
- R4: strap_oe_o bit 1 (pin B) and bit 0 (pin A) are 1 (output role) once valid_o is 1, and 0 (input role) before capture.
- R5: With hifreq_i = 0, the captured {A,B} maps to codes as follows: 00 gives code 0 (100 MHz), 01 gives code 2 (200 MHz), 10 gives code 1 (133 MHz) and 11 gives code 7 (reserved).
- R6: With hifreq_i = 1, the captured {A,B} maps as follows: 00 gives code 2 (200 MHz), 01 gives code 4 (400 MHz), 10 gives code 3 (266 MHz) and 11 gives code 7. hifreq_i acts on the code without a clock edge.
- R7: Before capture, freq_code_o is 0 (100 MHz) and valid_o is 0, whatever the level of hifreq_i.
- R8: test_req_i high at a rising edge sets test_mode_o. test_mode_o then stays 1 after test_req_i returns low.
- R9: In test mode, tristate_o equals strap_a_i with no clock (1 = high impedance, 0 = divided reference) and strap_oe_o bit 0 is 0. Changes on strap_b_i leave latched_b_o unchanged.
- R10: Reset clears test mode and returns every output to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power cycle) |
| pwrgd_ni | input | 1 | Asynchronous active-low power-good strobe |
| strap_a_i | input | 1 | Frequency strap A (live pin level) |
| strap_b_i | input | 1 | Frequency strap B (live pin level) |
| hifreq_i | input | 1 | Register bit selecting the doubled frequency table |
| test_req_i | input | 1 | Register bit requesting test mode |
| valid_o | output | 1 | Straps have been captured |
| latched_a_o | output | 1 | Captured strap A |
| latched_b_o | output | 1 | Captured strap B |
| freq_code_o | output | 3 | CPU frequency code: 0=100, 1=133, 2=200, 3=266, 4=400, 7=reserved |
| test_mode_o | output | 1 | Sticky test mode flag |
| tristate_o | output | 1 | Test-mode request to put all clock outputs in high impedance |
| strap_oe_o | output | 2 | Pin direction, bit 1 = pin B, bit 0 = pin A, 1 = output |

## Verification
Strap capture and the test-mode request can land on the same rising edge. In that case pin A must keep its input role while pin B switches to output, and the frozen strap pair must still be the one present at the capture edge. The bench raises test_req_i on the very edge where the synchronised strobe first reads low. It then checks that valid_o and test_mode_o rise together, that strap_oe_o reads 2'b10, and that tristate_o follows strap_a_i at once while latched_a_o stays at its captured value.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    FREQ_100  = 3'd0,
    FREQ_133  = 3'd1,
    FREQ_200  = 3'd2,
    FREQ_266  = 3'd3,
    FREQ_400  = 3'd4,
    FREQ_RSVD = 3'd7
  } freq_code_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= RESET_VAL;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrgd_sync_ni,
  input  logic strap_a_i,
  input  logic strap_b_i,
  output logic valid_o,
  output logic lat_a_o,
  output logic lat_b_o
);
  logic valid_q, lat_a_q, lat_b_q;

  // one-shot: only the first low sample loads the straps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lat_a_q <= 1'b0;
      lat_b_q <= 1'b0;
    end else if (!valid_q && !pwrgd_sync_ni) begin
      valid_q <= 1'b1;
      lat_a_q <= strap_a_i;
      lat_b_q <= strap_b_i;
    end
  end

  assign valid_o = valid_q;
  assign lat_a_o = lat_a_q;
  assign lat_b_o = lat_b_q;

  assert_capture_on_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(!pwrgd_sync_ni));
  assert_valid_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
  assert_latch_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> ($stable(lat_a_q) && $stable(lat_b_q)));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_latch_pkg::*;
(
  input  logic              valid_i,
  input  logic              lat_a_i,
  input  logic              lat_b_i,
  input  logic              hifreq_i,
  output logic [CODE_W-1:0] code_o
);
  freq_code_e code;

  always_comb begin
    code = FREQ_100;
    if (valid_i) begin
      unique case ({lat_a_i, lat_b_i})
        2'b00:   code = hifreq_i ? FREQ_200 : FREQ_100;
        2'b01:   code = hifreq_i ? FREQ_400 : FREQ_200;
        2'b10:   code = hifreq_i ? FREQ_266 : FREQ_133;
        default: code = FREQ_RSVD;
      endcase
    end
  end

  assign code_o = code;
endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_req_i,
  input  logic strap_a_i,
  output logic test_o,
  output logic tristate_o
);
  logic test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         test_q <= 1'b0;
    else if (test_req_i) test_q <= 1'b1;
  end

  // live, unclocked select: A=1 high-Z, A=0 divided reference
  assign test_o     = test_q;
  assign tristate_o = test_q & strap_a_i;

  assert_test_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_q |=> test_q);
  assert_test_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_req_i |=> test_q);
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
  import strap_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrgd_ni,
  input  logic              strap_a_i,
  input  logic              strap_b_i,
  input  logic              hifreq_i,
  input  logic              test_req_i,
  output logic              valid_o,
  output logic              latched_a_o,
  output logic              latched_b_o,
  output logic [CODE_W-1:0] freq_code_o,
  output logic              test_mode_o,
  output logic              tristate_o,
  output logic [1:0]        strap_oe_o
);
  logic pwrgd_sync_n;

  strap_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwrgd_ni),
    .q_o   (pwrgd_sync_n)
  );

  strap_capture u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwrgd_sync_ni(pwrgd_sync_n),
    .strap_a_i    (strap_a_i),
    .strap_b_i    (strap_b_i),
    .valid_o      (valid_o),
    .lat_a_o      (latched_a_o),
    .lat_b_o      (latched_b_o)
  );

  strap_decode u_dec (
    .valid_i (valid_o),
    .lat_a_i (latched_a_o),
    .lat_b_i (latched_b_o),
    .hifreq_i(hifreq_i),
    .code_o  (freq_code_o)
  );

  strap_test_ctrl u_test (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .test_req_i(test_req_i),
    .strap_a_i (strap_a_i),
    .test_o    (test_mode_o),
    .tristate_o(tristate_o)
  );

  // pin A stays an input in test mode so its level can be read live
  assign strap_oe_o = {valid_o, valid_o & ~test_mode_o};

  assert_code_before_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (freq_code_o == FREQ_100));
  assert_pin_a_input_in_test_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tristate_o |-> !strap_oe_o[0]);
  assert_pins_out_after_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> strap_oe_o[1]);
endmodule

// File: tb/sim_strap_latch_top.sv
module sim_strap_latch_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrgd_n = 1'b1;
  logic       sa = 1'b0, sb = 1'b0, hif = 1'b0, treq = 1'b0;
  logic       valid, la, lb, tm, ts;
  logic [2:0] code;
  logic [1:0] oe;

  always #2.5 clk = ~clk;

  strap_latch_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwrgd_ni(pwrgd_n),
    .strap_a_i(sa), .strap_b_i(sb), .hifreq_i(hif), .test_req_i(treq),
    .valid_o(valid), .latched_a_o(la), .latched_b_o(lb),
    .freq_code_o(code), .test_mode_o(tm), .tristate_o(ts), .strap_oe_o(oe)
  );

  typedef struct {
    string      req;
    logic [9:0] bits;  // {valid,code,la,lb,tm,ts,oe} minus nothing: 1+3+1+1+1+1+2
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_vec = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  function automatic logic [9:0] actual();
    return {valid, code, la, lb, tm, ts, oe};
  endfunction

  // monitor: pops expected items and compares with the live outputs
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (actual() !== e.bits) begin
        n_err++;
        $display("FAIL %s: actual %b expected %b ({valid,code,la,lb,tm,ts,oe})",
                 e.req, actual(), e.bits);
      end
    end
  end

  task automatic expect_o(string req, logic v, logic [2:0] c, logic a, logic b,
                          logic t, logic z, logic [1:0] o);
    exp_t e;
    e.req  = req;
    e.bits = {v, c, a, b, t, z, o};
    q.push_back(e);
    ->chk_ev;
    #0.1;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwrgd_n = 1'b1; treq = 1'b0;
    tick(2);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic capture(logic a, logic b);
    do_reset();
    @(negedge clk);
    sa = a; sb = b; pwrgd_n = 1'b0;
    tick(3);
  endtask

  function automatic logic [2:0] ref_code(logic a, logic b, logic h);
    case ({a, b})
      2'b00:   return h ? 3'd2 : 3'd0;
      2'b01:   return h ? 3'd4 : 3'd2;
      2'b10:   return h ? 3'd3 : 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  task automatic finish_run();
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    tick(1);
    expect_o("R1 in reset", 0, 0, 0, 0, 0, 0, 2'b00);
    do_reset();
    expect_o("R1 after release", 0, 0, 0, 0, 0, 0, 2'b00);

    // R7 code stays 100 before capture with hifreq high
    @(negedge clk); hif = 1'b1; sa = 1'b1; sb = 1'b0;
    tick(4);
    expect_o("R7 precapture hifreq", 0, 0, 0, 0, 0, 0, 2'b00);
    hif = 1'b0;

    // R2 synchroniser latency
    @(negedge clk); sa = 1'b0; sb = 1'b1; pwrgd_n = 1'b0;
    tick(2);
    expect_o("R2 not yet after 2 edges", 0, 0, 0, 0, 0, 0, 2'b00);
    tick(1);
    expect_o("R2 captured after 3 edges / R4 oe", 1, 3'd2, 0, 1, 0, 0, 2'b11);

    // R6 live hifreq
    hif = 1'b1; #0.5;
    expect_o("R6 live hifreq", 1, 3'd4, 0, 1, 0, 0, 2'b11);

    // R3 later strap / strobe activity ignored
    @(negedge clk); sa = 1'b1; sb = 1'b0; pwrgd_n = 1'b1;
    tick(4);
    @(negedge clk); pwrgd_n = 1'b0;
    tick(4);
    expect_o("R3 locked out", 1, 3'd4, 0, 1, 0, 0, 2'b11);

    // R5 / R6 full decode sweep
    for (int i = 0; i < 8; i++) begin
      logic a, b, h;
      {h, a, b} = 3'(i);
      hif = h;
      capture(a, b);
      expect_o(h ? "R6 decode" : "R5 decode", 1, ref_code(a, b, h), a, b, 0, 0, 2'b11);
    end
    hif = 1'b0;

    // R8 / R9 test mode after capture
    capture(1'b1, 1'b0);
    @(negedge clk); treq = 1'b1;
    tick(1);
    @(negedge clk); treq = 1'b0; sa = 1'b0;
    tick(3);
    expect_o("R8 sticky test / R9 refdiv", 1, 3'd1, 1, 0, 1, 0, 2'b10);
    sa = 1'b1; #0.5;
    expect_o("R9 async hi-z", 1, 3'd1, 1, 0, 1, 1, 2'b10);
    sb = 1'b1; sa = 1'b0; #0.5;
    expect_o("R9 strap B ignored", 1, 3'd1, 1, 0, 1, 0, 2'b10);

    // capture and test request on the same edge
    do_reset();
    @(negedge clk); sa = 1'b0; sb = 1'b1; pwrgd_n = 1'b0;
    tick(2);
    @(negedge clk); treq = 1'b1;
    tick(1);
    expect_o("R2 R8 same-edge capture+test", 1, 3'd2, 0, 1, 1, 0, 2'b10);
    @(negedge clk); treq = 1'b0; sa = 1'b1; #0.5;
    expect_o("R9 same-edge live select", 1, 3'd2, 0, 1, 1, 1, 2'b10);

    // R10 reset exits test mode
    do_reset();
    expect_o("R10 reset clears test", 0, 0, 0, 0, 0, 0, 2'b00);

    done = 1'b1;
    finish_run();
  end
endmodule